// File: doc/BRIEF.md
# Read-Strobe Delay Window Calibrator

This block is a sequencer that tunes the read-strobe delay of one or two DDR byte lanes. Each lane's delay has two levels: a coarse tap and a fine tap. On a start pulse the block captures the requested lane count and an 8-bit DLL master-delay reading. For each lane it then runs four sweeps that move one tap per trial. The sweeps find the upper edge of the passing window (coarse first, then fine) and the lower edge (coarse first, then fine). The lower sweeps stop at floors derived from the DLL reading.

Every trial hands a full candidate delay word and a bias code to an external trial engine. The engine runs the memory test and answers with pass or fail. When all four sweeps of a lane are done, the block computes a carry-adjusted midpoint of the window and writes it into that lane's byte. It then moves to the next lane. When the last lane is done it raises a one-cycle done pulse and presents the final delay word.

For the whole run the block asks the memory controller to hold off automatic self-refresh and to clear the strobe gating window of the active lanes. Both requests are dropped at the end of the run.

Top module: `dqs_window_cal`

## Requirements
- R1: After reset, busy_o, trial_req_o, done_o, sr_hold_o and gate_clr_o are all 0, and delay_o holds the starting word: coarse 7 and fine 4 in every lane (0x74 per byte).
- R2: A start_i pulse while idle begins a run and raises busy_o on the next cycle. A start_i pulse while busy has no effect on the trial sequence or on the result.
- R3: Only one trial is outstanding at a time. trial_req_o stays high, with trial_word_o and trial_bias_o unchanged, until the cycle in which trial_ack_i is sampled high. trial_req_o is low in the cycle after that acknowledge.
- R4: Upper coarse sweep: fine is held at 15 and coarse steps 7, 8, … 15. The first failing coarse value v gives a maximum of max(v-1, 7). If no trial fails, the maximum is 15.
- R5: Upper fine sweep: coarse is held at the found maximum and fine steps 0 … 15. The first failure at v gives r = max(v-1, 0); no failure gives r = 15. If r is 0, the coarse maximum is decremented and the fine maximum is 15. Otherwise the fine maximum is r-1.
- R6: Lower coarse sweep: fine is held at 0 and coarse steps downward from 6 to the coarse floor. The first failure at v gives min(v+1, 6); no failure gives the floor. The coarse floor is 8 minus dll_i[7:4] when that nibble is at most 8, and 0 otherwise. A floor above 6 means no trial is issued and the floor itself is the result.
- R7: Lower fine sweep: coarse is held at the found minimum and fine steps downward from 15 to the fine floor. The first failure at v gives min(v+1, 15); no failure gives the floor. The fine floor is computed from dll_i[3:0] the same way as the coarse floor.
- R8: The lane result has coarse (cmax+cmin)>>1 and fine 4·((cmax+cmin) mod 2) + ((fmax+fmin)>>1). If that fine value is 16 or more, coarse is incremented and 8 is subtracted from fine.
- R9: Trials of the two upper sweeps carry trial_bias_o = 3. Trials of the two lower sweeps carry trial_bias_o = 1.
- R10: Lane i uses bits [8i+7:8i] of the word, with coarse in the upper nibble and fine in the lower. A trial word is the current word with the lane under calibration replaced by the candidate byte. Finished lanes keep their results, and lanes beyond lanes_i (1 or 2) keep 0x74. Lanes are calibrated in ascending order.
- R11: While busy, sr_hold_o is 1 and gate_clr_o has bit i set for each active lane. Both return to 0 when the run ends.
- R12: At the end of a run done_o is high for exactly one cycle, busy_o is low in that cycle, and delay_o carries the final word from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| lanes_i | input | 2 | Lane count, 1 or 2 |
| dll_i | input | 8 | DLL master-delay reading |
| trial_ack_i | input | 1 | Trial engine acknowledge |
| trial_pass_i | input | 1 | Trial result, 1 = pass, valid with ack |
| trial_req_o | output | 1 | Trial request |
| trial_word_o | output | 16 | Candidate delay word |
| trial_bias_o | output | 2 | Test bias code for the trial |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| delay_o | output | 16 | Current/final delay word |
| sr_hold_o | output | 1 | Suppress automatic self-refresh |
| gate_clr_o | output | 2 | Clear strobe gating window, per lane |

## Verification
The bench builds the block with its default of two lanes. It sweeps one-lane and two-lane runs over four DLL readings: one gives a coarse floor above 6, so the lower coarse sweep issues no trials, and the others give floors of 6, 0 and 0. Each lane's passing window is set as a range of coarse·8+fine. The range edges are chosen so that each sweep's first-fail, no-fail and clamp outcomes all occur, and so does the fine carry of the midpoint. The bench's trial engine compares every requested word and bias with a sequence computed arithmetically from the requirements. It answers with varied latency and injects a start pulse during busy runs.

// File: rtl/dqs_window_cal.sv
module dqs_window_cal #(
  parameter int LANES = 2,
  localparam int LCW = $clog2(LANES + 1),
  localparam int WORD_W = 8 * LANES,
  localparam int LIDX = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LCW-1:0]    lanes_i,
  input  logic [7:0]        dll_i,
  input  logic              trial_ack_i,
  input  logic              trial_pass_i,
  output logic              trial_req_o,
  output logic [WORD_W-1:0] trial_word_o,
  output logic [1:0]        trial_bias_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] delay_o,
  output logic              sr_hold_o,
  output logic [LANES-1:0]  gate_clr_o
);

  localparam logic [WORD_W-1:0] INIT_WORD = {LANES{8'h74}};

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_TRIAL, S_GAP, S_CENTRE} st_t;
  typedef enum logic [1:0] {P_MAXC, P_MAXF, P_MINC, P_MINF} ph_t;

  st_t st;
  ph_t ph;
  logic [3:0] v, cmax, fmax, cmin, fmin, clim, flim;
  logic [LIDX-1:0] lane;
  logic [LCW-1:0] nl;
  logic [WORD_W-1:0] cur;
  logic done_q;

  logic [3:0] cand_c, cand_f, start_v, end_v;
  logic [WORD_W-1:0] word;
  logic last, fail;
  logic [4:0] csum, fsum, ff5;
  logic [3:0] cen_c, cen_f, r_maxf;
  logic [LCW-1:0] nl_in;

  assign busy_o       = (st != S_IDLE);
  assign done_o       = done_q;
  assign delay_o      = cur;
  assign sr_hold_o    = busy_o;
  assign trial_req_o  = (st == S_TRIAL);
  assign trial_word_o = word;
  assign trial_bias_o = (ph == P_MAXC || ph == P_MAXF) ? 2'd3 : 2'd1;
  assign last         = (v == end_v);
  assign fail         = !trial_pass_i;

  assign nl_in = (lanes_i == '0) ? LCW'(1) :
                 (lanes_i > LCW'(LANES)) ? LCW'(LANES) : lanes_i;

  for (genvar g = 0; g < LANES; g++) begin : g_gate
    assign gate_clr_o[g] = busy_o && (LCW'(g) < nl);
  end

  always_comb begin
    case (ph)
      P_MAXC:  begin cand_c = v;    cand_f = 4'd15; start_v = 4'd7;  end_v = 4'd15; end
      P_MAXF:  begin cand_c = cmax; cand_f = v;     start_v = 4'd0;  end_v = 4'd15; end
      P_MINC:  begin cand_c = v;    cand_f = 4'd0;  start_v = 4'd6;  end_v = clim;  end
      default: begin cand_c = cmin; cand_f = v;     start_v = 4'd15; end_v = flim;  end
    endcase
  end

  always_comb begin
    word = cur;
    for (int i = 0; i < LANES; i++)
      if (i == int'(lane)) word[8*i +: 8] = {cand_c, cand_f};
  end

  always_comb begin
    csum = {1'b0, cmax} + {1'b0, cmin};
    fsum = {1'b0, fmax} + {1'b0, fmin};
    ff5  = {2'b00, csum[0], 2'b00} + {1'b0, fsum[4:1]};
    if (ff5 >= 5'd16) begin
      cen_c = csum[4:1] + 4'd1;
      cen_f = 4'(ff5 - 5'd8);
    end else begin
      cen_c = csum[4:1];
      cen_f = ff5[3:0];
    end
  end

  assign r_maxf = fail ? ((v == 4'd0) ? 4'd0 : v - 4'd1) : 4'd15;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_MAXC; v <= '0; lane <= '0; nl <= LCW'(1);
      cmax <= '0; fmax <= '0; cmin <= '0; fmin <= '0; clim <= '0; flim <= '0;
      cur <= INIT_WORD; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          cur  <= INIT_WORD;
          lane <= '0;
          ph   <= P_MAXC;
          nl   <= nl_in;
          clim <= (dll_i[7:4] <= 4'd8) ? 4'd8 - dll_i[7:4] : 4'd0;
          flim <= (dll_i[3:0] <= 4'd8) ? 4'd8 - dll_i[3:0] : 4'd0;
          st   <= S_SETUP;
        end
        S_SETUP: begin
          v <= start_v;
          if (ph == P_MINC && clim > 4'd6) begin
            cmin <= clim;
            ph   <= P_MINF;
          end else begin
            st <= S_TRIAL;
          end
        end
        S_GAP: st <= S_TRIAL;
        S_TRIAL: if (trial_ack_i) begin
          if (fail || last) begin
            case (ph)
              P_MAXC: cmax <= fail ? ((v == 4'd7) ? 4'd7 : v - 4'd1) : 4'd15;
              P_MAXF: if (r_maxf == 4'd0) begin
                        cmax <= cmax - 4'd1;
                        fmax <= 4'd15;
                      end else begin
                        fmax <= r_maxf - 4'd1;
                      end
              P_MINC: cmin <= fail ? ((v == 4'd6) ? 4'd6 : v + 4'd1) : clim;
              default: fmin <= fail ? ((v == 4'd15) ? 4'd15 : v + 4'd1) : flim;
            endcase
            if (ph == P_MINF) st <= S_CENTRE;
            else begin
              ph <= ph_t'(ph + 2'd1);
              st <= S_SETUP;
            end
          end else begin
            v  <= (ph == P_MAXC || ph == P_MAXF) ? v + 4'd1 : v - 4'd1;
            st <= S_GAP;
          end
        end
        S_CENTRE: begin
          for (int i = 0; i < LANES; i++)
            if (i == int'(lane)) cur[8*i +: 8] <= {cen_c, cen_f};
          if (LCW'(lane) + LCW'(1) < nl) begin
            lane <= lane + LIDX'(1);
            ph   <= P_MAXC;
            st   <= S_SETUP;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req_o && !trial_ack_i |=> trial_req_o && $stable(trial_word_o) && $stable(trial_bias_o));

  // R3
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req_o && trial_ack_i |=> !trial_req_o);

  // R9
  bias_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req_o |-> (trial_bias_o == 2'd1 || trial_bias_o == 2'd3));

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> busy_o || done_o);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R6
  coarse_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req_o && ph == P_MINC |-> v >= clim);

endmodule

// File: tb/dqs_window_cal_tb.sv
module dqs_window_cal_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [1:0] lanes_i = 2'd1;
  logic [7:0] dll_i = 8'h00;
  logic trial_ack_i = 1'b0, trial_pass_i = 1'b0;
  logic trial_req_o, busy_o, done_o, sr_hold_o;
  logic [15:0] trial_word_o, delay_o;
  logic [1:0] trial_bias_o, gate_clr_o;

  always #2 clk = ~clk;

  dqs_window_cal dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lanes_i(lanes_i), .dll_i(dll_i),
    .trial_ack_i(trial_ack_i), .trial_pass_i(trial_pass_i), .trial_req_o(trial_req_o),
    .trial_word_o(trial_word_o), .trial_bias_o(trial_bias_o), .busy_o(busy_o),
    .done_o(done_o), .delay_o(delay_o), .sr_hold_o(sr_hold_o), .gate_clr_o(gate_clr_o));

  int checks = 0, fails = 0;
  int lo0, hi0, lo1, hi1, cur_nl;
  logic [15:0] exp_w [128];
  logic [1:0]  exp_b [128];
  int          exp_p [128];
  int n_exp, k;
  logic [15:0] exp_final;

  function automatic string tag(int p);
    case (p)
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic bit inw(logic [7:0] b, int lo, int hi);
    int d;
    d = int'(b[7:4]) * 8 + int'(b[3:0]);
    return d >= lo && d <= hi;
  endfunction

  function automatic bit okw(logic [15:0] w);
    return inw(w[7:0], lo0, hi0) && inw(w[15:8], lo1, hi1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int base, int sh, int c, int f, int bias, int p);
    exp_w[n_exp] = 16'(base | (((c << 4) | f) << sh));
    exp_b[n_exp] = 2'(bias);
    exp_p[n_exp] = p;
    n_exp++;
  endtask

  // Expected sequence and result, from R4..R10
  task automatic build_exp(int nl, logic [7:0] dll);
    int cur, base, sh, cmax, fmax, cmin, fmin, r, cl, fl, s, cc, ff;
    n_exp = 0;
    cur = 'h7474;
    cl = (dll[7:4] <= 8) ? 8 - int'(dll[7:4]) : 0;
    fl = (dll[3:0] <= 8) ? 8 - int'(dll[3:0]) : 0;
    for (int l = 0; l < nl; l++) begin
      sh = 8 * l;
      base = cur & ~('hff << sh);
      cmax = 15;
      for (int v = 7; v <= 15; v++) begin
        push(base, sh, v, 15, 3, 4);
        if (!okw(exp_w[n_exp-1])) begin cmax = (v - 1 > 7) ? v - 1 : 7; break; end
      end
      r = 15;
      for (int v = 0; v <= 15; v++) begin
        push(base, sh, cmax, v, 3, 5);
        if (!okw(exp_w[n_exp-1])) begin r = (v - 1 > 0) ? v - 1 : 0; break; end
      end
      if (r == 0) begin cmax--; fmax = 15; end else fmax = r - 1;
      cmin = cl;
      for (int v = 6; v >= cl; v--) begin
        push(base, sh, v, 0, 1, 6);
        if (!okw(exp_w[n_exp-1])) begin cmin = (v + 1 < 6) ? v + 1 : 6; break; end
      end
      fmin = fl;
      for (int v = 15; v >= fl; v--) begin
        push(base, sh, cmin, v, 1, 7);
        if (!okw(exp_w[n_exp-1])) begin fmin = (v + 1 < 15) ? v + 1 : 15; break; end
      end
      s = cmax + cmin;
      cc = s / 2;
      ff = 4 * (s % 2) + (fmax + fmin) / 2;
      if (ff >= 16) begin cc++; ff -= 8; end
      cur = base | (((cc << 4) | ff) << sh);
    end
    exp_final = 16'(cur);
  endtask

  // Trial engine: R3, R9, R10, R11 and the sweep orders R4..R7
  initial begin
    logic [15:0] w;
    logic [1:0] b;
    forever begin
      @(negedge clk);
      if (trial_req_o) begin
        w = trial_word_o;
        b = trial_bias_o;
        if (k < n_exp) begin
          chk(w == exp_w[k], tag(exp_p[k]), int'(w), int'(exp_w[k]));
          chk(b == exp_b[k], "R9", int'(b), int'(exp_b[k]));
        end else chk(0, "R4", k, n_exp);
        chk(sr_hold_o && gate_clr_o == ((cur_nl == 2) ? 2'b11 : 2'b01), "R11",
            int'({sr_hold_o, gate_clr_o}), (cur_nl == 2) ? 7 : 5);
        repeat (k % 3) begin
          @(negedge clk);
          chk(trial_req_o && trial_word_o == w && trial_bias_o == b, "R3",
              int'(trial_word_o), int'(w));
        end
        k++;
        trial_ack_i = 1'b1;
        trial_pass_i = okw(w);
        @(negedge clk);
        trial_ack_i = 1'b0;
        chk(!trial_req_o, "R3", int'(trial_req_o), 0);
      end
    end
  end

  task automatic run(int nl, logic [7:0] dll);
    int cyc, dones;
    bit seen;
    cur_nl = nl;
    build_exp(nl, dll);
    k = 0;
    @(negedge clk);
    lanes_i = 2'(nl);
    dll_i = dll;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R2", int'(busy_o), 1);
    dones = 0;
    seen = 0;
    cyc = 0;
    while (!seen && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start_i = (cyc == 15 && busy_o);
      if (done_o) begin
        seen = 1;
        dones++;
        chk(delay_o == exp_final, "R8/R10", int'(delay_o), int'(exp_final));
        chk(!busy_o && !sr_hold_o && gate_clr_o == 2'b00, "R11",
            int'({busy_o, sr_hold_o, gate_clr_o}), 0);
      end
    end
    start_i = 1'b0;
    @(negedge clk);
    chk(!done_o && dones == 1, "R12", dones + int'(done_o), 1);
    chk(delay_o == exp_final, "R12", int'(delay_o), int'(exp_final));
    chk(k == n_exp, "R2", k, n_exp);
  endtask

  initial begin
    int los[4] = '{10, 30, 52, 60};
    int his[4] = '{60, 75, 100, 135};
    logic [7:0] dlls[4] = '{8'h00, 8'h26, 8'h88, 8'hF9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy_o && !trial_req_o && !done_o && !sr_hold_o && gate_clr_o == 2'b00,
        "R1", int'({busy_o, trial_req_o, done_o, sr_hold_o, gate_clr_o}), 0);
    chk(delay_o == 16'h7474, "R1", int'(delay_o), 'h7474);
    for (int a = 0; a < 4; a++)
      for (int h = 0; h < 4; h++)
        for (int d = 0; d < 4; d++)
          for (int n = 1; n <= 2; n++) begin
            lo0 = los[a];
            hi0 = his[h];
            lo1 = (lo0 + 7 < 60) ? lo0 + 7 : 60;
            hi1 = (hi0 - 9 > 60) ? hi0 - 9 : 60;
            run(n, dlls[d]);
          end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule